// File: doc/BRIEF.md
# Segmented Dynamic-Precision Adder

This block is an unsigned adder whose operand width is cut into equal segments. A control word, which can change on every cycle, says for each internal boundary whether the two neighbouring segments form one wider lane or stay apart. Several independent additions of mixed widths can therefore share one datapath in the same cycle: eight 4-bit lanes, one 32-bit lane, or any mix of adjacent groups. No reconfiguration is needed.

Each group takes the same single carry-in bit and reports its own carry-out on the flag of its topmost segment. The core is a ripple-carry chain. At each segment boundary a multiplexer either passes the lower segment's carry up or substitutes the shared carry-in. An AND gate masks the lower segment's carry so that it is reported only when that segment ends a group. A parameter selects an optional output register.

Top module: `segDynAdder`

## Requirements
- R1: The operands are `DATA_W` bits split into `NUM_SEG` segments of `DATA_W/NUM_SEG` bits. Segment s covers bits [s*SEG_W +: SEG_W].
- R2: `joinCtrl[i]` = 1 joins segment i with segment i+1. The sum of a joined group equals (A + B + carryIn) modulo 2^(group width), taken over the group's bit range.
- R3: `joinCtrl[i]` = 0 stops any carry from segment i reaching segment i+1. The sum of a group never depends on operand bits outside it.
- R4: The lowest segment of every group takes the shared `carryIn` as its carry-in.
- R5: For a segment that is the top of a group (the top segment, or one with `joinCtrl[s]` = 0), `carryOut[s]` is the carry out of that group's addition.
- R6: `carryOut[s]` is 0 for every segment s whose upper boundary is joined (`joinCtrl[s]` = 1).
- R7: With every control bit set, the block is a plain `DATA_W`-bit adder: {carryOut[NUM_SEG-1], sumOut} = A + B + carryIn.
- R8: With every control bit clear, the block is `NUM_SEG` independent adders, each carrying out on its own flag.
- R9: With `REG_OUT` = 1, results appear one clock after the inputs. While `rstN` is low, the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opA | input | DATA_W | First unsigned operand |
| opB | input | DATA_W | Second unsigned operand |
| joinCtrl | input | NUM_SEG-1 | Bit i = 1 joins segment i to segment i+1 |
| carryIn | input | 1 | Carry-in shared by every group |
| sumOut | output | DATA_W | Concatenated group sums |
| carryOut | output | NUM_SEG | Per-segment carry flag, valid at group tops |

## Verification
The assertions assume that the operands, control word and carry-in are known (no X) at every rising edge after reset. They also assume that these inputs are sampled together, one clock before the results they are compared against. The bench keeps within this by driving every input only on falling edges, starting from time zero. It holds each set for a full cycle and reads the outputs on the next falling edge. Random and directed control words cover all-joined, all-split and mixed groupings. Operand patterns drive all-ones segments so that a leaked or missing boundary carry changes the visible result.

// File: rtl/segadd_pkg.sv
package segadd_pkg;

  // Per-segment strobes from the boundary decoder to the datapath.
  typedef struct packed {
    logic takeShared; // segment starts a group: use the shared carry-in
    logic groupTop;   // segment ends a group: its carry is reported
  } segStrobe_t;

endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segadd_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic [NUM_SEG-2:0]            joinCtrl,
  output segStrobe_t [NUM_SEG-1:0]      strobes
);

  // Extend the control word with an implicit "open" boundary above the top.
  logic [NUM_SEG-1:0] joinAbove;
  logic [NUM_SEG-1:0] joinBelow;

  assign joinAbove = {1'b0, joinCtrl};
  assign joinBelow = {joinCtrl, 1'b0};

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign strobes[s].takeShared = ~joinBelow[s];
    assign strobes[s].groupTop   = ~joinAbove[s];
  end

endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segadd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SEG = 8
) (
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  input  logic                     carryIn,
  input  segStrobe_t [NUM_SEG-1:0] strobes,
  output logic [DATA_W-1:0]        sumComb,
  output logic [NUM_SEG-1:0]       carryComb
);

  localparam int SEG_W = DATA_W / NUM_SEG;

  logic [NUM_SEG-1:0] rawCarry;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic              segCin;
    logic [SEG_W-1:0]  segA;
    logic [SEG_W-1:0]  segB;
    logic [SEG_W-1:0]  segSum;
    logic [SEG_W:0]    chain;

    assign segA = opA[s*SEG_W +: SEG_W];
    assign segB = opB[s*SEG_W +: SEG_W];

    // Boundary multiplexer: the carry from below, or the shared carry-in.
    if (s == 0) begin : g_base
      assign segCin = carryIn;
    end else begin : g_upper
      assign segCin = strobes[s].takeShared ? carryIn : rawCarry[s-1];
    end

    // Ripple chain inside the segment.
    always_comb begin
      chain[0] = segCin;
      for (int j = 0; j < SEG_W; j++) begin
        segSum[j]  = segA[j] ^ segB[j] ^ chain[j];
        chain[j+1] = (segA[j] & segB[j]) | (chain[j] & (segA[j] ^ segB[j]));
      end
    end

    assign sumComb[s*SEG_W +: SEG_W] = segSum;
    assign rawCarry[s]  = chain[SEG_W];
    // Boundary AND gate: report only at the top of a group.
    assign carryComb[s] = rawCarry[s] & strobes[s].groupTop;
  end

endmodule

// File: rtl/segOutStage.sv
module segOutStage #(
  parameter int DATA_W  = 32,
  parameter int NUM_SEG = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  sumComb,
  input  logic [NUM_SEG-1:0] carryComb,
  output logic [DATA_W-1:0]  sumOut,
  output logic [NUM_SEG-1:0] carryOut
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumOut   <= '0;
        carryOut <= '0;
      end else begin
        sumOut   <= sumComb;
        carryOut <= carryComb;
      end
    end
  end else begin : g_comb
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
    assign sumOut    = sumComb;
    assign carryOut  = carryComb;
  end

endmodule

// File: rtl/segDynAdder.sv
module segDynAdder
  import segadd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SEG = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [NUM_SEG-2:0] joinCtrl,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  sumOut,
  output logic [NUM_SEG-1:0] carryOut
);

  segStrobe_t [NUM_SEG-1:0] strobes;
  logic [DATA_W-1:0]        sumComb;
  logic [NUM_SEG-1:0]       carryComb;

  segCtrl #(.NUM_SEG(NUM_SEG)) ctrl_i (
    .joinCtrl (joinCtrl),
    .strobes  (strobes)
  );

  segDatapath #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) dp_i (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .strobes   (strobes),
    .sumComb   (sumComb),
    .carryComb (carryComb)
  );

  segOutStage #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .REG_OUT(REG_OUT)) out_i (
    .clk       (clk),
    .rstN      (rstN),
    .sumComb   (sumComb),
    .carryComb (carryComb),
    .sumOut    (sumOut),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/segDynAdder_chk.sv
module segDynAdder_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_SEG = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [NUM_SEG-2:0] joinCtrl,
  input logic               carryIn,
  input logic [DATA_W-1:0]  sumOut,
  input logic [NUM_SEG-1:0] carryOut
);

  localparam int SEG_W = DATA_W / NUM_SEG;
  localparam int TOP_LO = (NUM_SEG - 1) * SEG_W;

  if (REG_OUT) begin : g_reg
    logic               pastValid;
    logic [DATA_W-1:0]  prevA;
    logic [DATA_W-1:0]  prevB;
    logic [NUM_SEG-2:0] prevJoin;
    logic               prevCin;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pastValid <= 1'b0;
        prevA     <= '0;
        prevB     <= '0;
        prevJoin  <= '0;
        prevCin   <= 1'b0;
      end else begin
        pastValid <= 1'b1;
        prevA     <= opA;
        prevB     <= opB;
        prevJoin  <= joinCtrl;
        prevCin   <= carryIn;
      end
    end

    logic [DATA_W:0] fullRef;
    logic [SEG_W:0]  lowRef;
    logic [SEG_W:0]  topRef;

    assign fullRef = {1'b0, prevA} + {1'b0, prevB} + {{DATA_W{1'b0}}, prevCin};
    assign lowRef  = {1'b0, prevA[SEG_W-1:0]} + {1'b0, prevB[SEG_W-1:0]}
                   + {{SEG_W{1'b0}}, prevCin};
    assign topRef  = {1'b0, prevA[TOP_LO +: SEG_W]} + {1'b0, prevB[TOP_LO +: SEG_W]}
                   + {{SEG_W{1'b0}}, prevCin};

    // R6: a joined upper boundary never reports a carry
    a_r6_joined_no_flag: assert property (@(posedge clk) disable iff (!rstN)
      pastValid |-> ((carryOut[NUM_SEG-2:0] & prevJoin) == '0));

    // R7: all joined behaves as a single wide adder
    a_r7_full_width_sum: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && (&prevJoin)) |-> ({carryOut[NUM_SEG-1], sumOut} == fullRef));

    // R3: an open boundary above segment 0 isolates it
    a_r3_low_seg_isolated: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !prevJoin[0]) |-> ({carryOut[0], sumOut[SEG_W-1:0]} == lowRef));

    // R4: an open boundary below the top segment feeds it the shared carry-in
    a_r4_top_seg_shared_cin: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !prevJoin[NUM_SEG-2])
        |-> ({carryOut[NUM_SEG-1], sumOut[TOP_LO +: SEG_W]} == topRef));

    // R9: outputs held at zero while reset is asserted
    a_r9_reset_clear: assert property (@(posedge clk)
      !rstN |-> (sumOut == '0 && carryOut == '0));
  end else begin : g_comb
    always @(posedge clk) begin
      if (rstN) begin
        // R6
        a_r6_joined_no_flag: assert ((carryOut[NUM_SEG-2:0] & joinCtrl) == '0);
        // R7
        if (&joinCtrl) begin
          a_r7_full_width_sum: assert ({carryOut[NUM_SEG-1], sumOut} ==
            ({1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn}));
        end
      end
    end
  end

endmodule

bind segDynAdder segDynAdder_chk #(
  .DATA_W  (DATA_W),
  .NUM_SEG (NUM_SEG),
  .REG_OUT (REG_OUT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .opA      (opA),
  .opB      (opB),
  .joinCtrl (joinCtrl),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/segDynAdder_tb_top.sv
module segDynAdder_tb_top;

  localparam int DATA_W  = 32;
  localparam int NUM_SEG = 8;
  localparam int SEG_W   = DATA_W / NUM_SEG;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [DATA_W-1:0]  opA = '0;
  logic [DATA_W-1:0]  opB = '0;
  logic [NUM_SEG-2:0] joinCtrl = '0;
  logic               carryIn = 1'b0;
  logic [DATA_W-1:0]  sumOut;
  logic [NUM_SEG-1:0] carryOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  segDynAdder #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .REG_OUT(1'b1)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .joinCtrl (joinCtrl),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // Reference model, built from the requirements segment by segment.
  function automatic logic [DATA_W+NUM_SEG-1:0] refCalc(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
    input logic [NUM_SEG-2:0] jn, input logic cin);
    logic [DATA_W-1:0]  s;
    logic [NUM_SEG-1:0] c;
    logic [NUM_SEG-1:0] jx;
    logic               run;
    logic [SEG_W:0]     t;
    jx  = {1'b0, jn};
    run = cin;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (k > 0 && !jx[k-1]) run = cin;
      t = {1'b0, a[k*SEG_W +: SEG_W]} + {1'b0, b[k*SEG_W +: SEG_W]} + {{SEG_W{1'b0}}, run};
      s[k*SEG_W +: SEG_W] = t[SEG_W-1:0];
      run  = t[SEG_W];
      c[k] = jx[k] ? 1'b0 : run;
    end
    return {c, s};
  endfunction

  task automatic check(input string tag, input logic [DATA_W+NUM_SEG-1:0] act,
                       input logic [DATA_W+NUM_SEG-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual carry=%h sum=%h expected carry=%h sum=%h", tag,
               act[DATA_W +: NUM_SEG], act[DATA_W-1:0],
               exp[DATA_W +: NUM_SEG], exp[DATA_W-1:0]);
    end
  endtask

  // Drive at a falling edge; one rising edge later, read at the next falling edge.
  task automatic apply(input string tag, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] b, input logic [NUM_SEG-2:0] jn,
                       input logic cin);
    @(negedge clk);
    opA = a; opB = b; joinCtrl = jn; carryIn = cin;
    @(negedge clk);
    check(tag, {carryOut, sumOut}, refCalc(a, b, jn, cin));
  endtask

  task automatic testReset();
    #2;
    check("R9 reset state", {carryOut, sumOut}, '0);
    repeat (2) @(negedge clk);
    opA = '1; opB = '1; joinCtrl = '1; carryIn = 1'b1;
    @(negedge clk);
    check("R9 held in reset", {carryOut, sumOut}, '0);
    rstN = 1'b1;
  endtask

  task automatic testAllSplit();
    // R8, R1: segment s gets s + (s+1); no carry anywhere
    apply("R8 R1 split lanes", 32'h7654_3210, 32'h8765_4321, '0, 1'b0);
    // R8: all segments overflow independently
    apply("R8 split overflow", 32'hFFFF_FFFF, 32'h1111_1111, '0, 1'b0);
  endtask

  task automatic testSharedCin();
    // R4: every split lane of all-ones wraps to 0 with carry 1
    apply("R4 shared carry-in", 32'hFFFF_FFFF, 32'h0, '0, 1'b1);
    // R4: grouped lanes, carry-in enters each group base only once
    apply("R4 grouped carry-in", 32'h0F0F_0F0F, 32'h0, 7'b1010101, 1'b1);
  endtask

  task automatic testAllJoined();
    // R7: all-ones plus carry-in ripples through every boundary
    apply("R7 full ripple", 32'hFFFF_FFFF, 32'h0, '1, 1'b1);
    apply("R7 wide add", 32'h89AB_CDEF, 32'h7654_3211, '1, 1'b0);
    apply("R7 no overflow", 32'h1234_5678, 32'h0000_0001, '1, 1'b1);
  endtask

  task automatic testIsolation();
    // R3: lower lane overflows, upper lane must not see it
    apply("R3 no leak", 32'h0000_000F, 32'h0000_0001, 7'b1111110, 1'b0);
    // R6: joined lower pair overflows, flag only at its top
    @(negedge clk);
    opA = 32'h0000_00FF; opB = 32'h0000_0001; joinCtrl = 7'b0000001; carryIn = 1'b0;
    @(negedge clk);
    check("R6 inner flag clear", {31'b0, carryOut[0]}, 32'b0);
    check("R5 group top flag", {31'b0, carryOut[1]}, 32'b1);
  endtask

  task automatic testMixed();
    apply("R2 R5 mixed 16+8+4+4", 32'hFFF0_8001, 32'h0011_7FFF, 7'b1110100, 1'b1);
    apply("R2 R5 mixed pairs", 32'hA5A5_A5A5, 32'h5B5B_5B5B, 7'b1010101, 1'b0);
    for (int n = 0; n < 300; n++) begin
      apply("R2 R3 R5 R6 random", $urandom, $urandom, 7'($urandom), 1'($urandom));
    end
  endtask

  task automatic testLatency();
    @(negedge clk);
    opA = 32'h0000_0001; opB = 32'h0000_0001; joinCtrl = '1; carryIn = 1'b0;
    @(negedge clk);
    opA = 32'h0000_0100; opB = 32'h0000_0100;
    #1;
    check("R9 one-cycle latency", {carryOut, sumOut}, {8'h00, 32'h0000_0002});
    @(negedge clk);
    check("R9 next result", {carryOut, sumOut}, {8'h00, 32'h0000_0200});
  endtask

  initial begin
    testReset();
    testAllSplit();
    testSharedCin();
    testAllJoined();
    testIsolation();
    testMixed();
    testLatency();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule